// File: doc/BRIEF.md
# Dual-Mode Watchdog Counter

This block is an 8-bit supervision counter driven from the system clock through a programmable prescaler. It serves as a fail-safe watchdog: when the counter runs out, the block pulls a reset line. It can also serve as a plain periodic timer: when the counter runs out, a level interrupt is raised and the counter reloads itself. The host reaches it over a small register bus with a write strobe, a 2-bit address, 8-bit write data and combinational read data. Address 0 is control/status, address 1 is the reload value and address 2 is the feed port.

Once the watchdog function is enabled, it cannot be disabled except by power-on reset. While it is enabled, the control and reload registers accept a write only when the write comes right after a two-byte feed sequence. A force bit keeps the counter running no matter what the run bit says. The block has two synchronous resets. Power-on reset clears everything. The watchdog-reset input is normally looped back from the reset output and clears the working state, but it keeps the watchdog-enable bit and the overflow flag.

Top module: `dual_mode_watchdog`

## Requirements
- R1: After power-on reset, control (address 0) and reload (address 1) both read 8'h00, and the reset output, interrupt and flag outputs are all low.
- R2: The watchdog-enable bit (control bit 3) can be set by an accepted control write. Once set, it stays 1 through any later control write and through the watchdog-reset input. Only power-on reset clears it.
- R3: A counter overflow with bit 3 = 1 drives the reset output high. With bit 3 = 0 the reset output stays low.
- R4: While bit 3 = 1, a write to control or reload changes nothing unless the write on the bus just before it was the second byte of a correct feed.
- R5: The counter runs when run bit 0 = 1 or force bit 6 = 1. With both at 0 it holds. Writing bit 6 to 1 sets it, and a control write cannot clear it.
- R6: Writing 1 to control bit 1 loads the counter from the reload register and clears the prescaler. Bit 1 always reads 0.
- R7: After a refresh with reload value R, the overflow flag rises exactly max(255−R,1)×DIV clock edges after the refresh write edge.
- R8: The overflow flag (control bit 2, also the flag output) is set by an overflow. An accepted control write with bit 2 = 1 clears it. A locked write leaves it unchanged. The watchdog-reset input does not clear it. Power-on reset does.
- R9: At overflow the counter reloads from the reload register and keeps running, so the next overflow comes one full period after the previous one.
- R10: Each overflow in watchdog mode holds the reset output high for exactly DIV clock cycles.
- R11: A feed is a write of 8'h1E to address 2 followed directly by a write of 8'hE1 to address 2. A wrong byte or any other write in between cancels it. A correct feed unlocks exactly one later write.
- R12: The watchdog-reset input clears run, force, reload, counter, prescaler and feed state.
- R13: The interrupt output is high exactly when the flag is 1, the interrupt-enable input is 1 and bit 3 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Synchronous power-on reset, active high, clears all state |
| wd_rst_in | input | 1 | Synchronous watchdog reset, active high, keeps sticky bits |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 feed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq_en | input | 1 | External interrupt enable |
| wdt_reset_out | output | 1 | Watchdog reset request |
| irq_out | output | 1 | Timer interrupt request (level) |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench measures the exact edge on which the flag rises for reload values at the top of the range (254 and 255, where the period floors at one tick) and for random ones. A design with an off-by-one in the wrap point would miss these counts by DIV, and one that left out the floor would wait a full 256 ticks. Feed handling is exercised with random mixes of correct, corrupted and interrupted sequences before protected writes, which exposes a guard that accepts stale unlocks or lets one unlock be used twice. The tests also try to clear the force bit, the watchdog-enable bit and the flag through locked writes and through the watchdog-reset input; a design that gates these bits wrongly would show a changed readback. The width of the reset pulse and the reload-based period of the second overflow are also counted.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int unsigned CNT_W  = 8;
    localparam int unsigned DATA_W = CNT_W;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FEED   = 2'd2;

    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_REFRESH = 1;
    localparam int unsigned BIT_FLAG    = 2;
    localparam int unsigned BIT_RSTEN   = 3;
    localparam int unsigned BIT_FORCE   = 6;

    localparam logic [DATA_W-1:0] FEED_FIRST  = 8'h1E;
    localparam logic [DATA_W-1:0] FEED_SECOND = 8'hE1;

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_WRAP = CNT_MAX - 1'b1;

    typedef enum logic [1:0] {
        FEED_IDLE = 2'd0,
        FEED_HALF = 2'd1,
        FEED_OPEN = 2'd2
    } feed_state_e;

    typedef struct packed {
        logic force_on;
        logic rst_en;
        logic flag;
        logic run;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_byte(ctrl_t c);
        logic [DATA_W-1:0] b;
        b            = '0;
        b[BIT_RUN]   = c.run;
        b[BIT_FLAG]  = c.flag;
        b[BIT_RSTEN] = c.rst_en;
        b[BIT_FORCE] = c.force_on;
        return b;
    endfunction

    function automatic logic at_wrap(logic [CNT_W-1:0] v);
        return v >= CNT_WRAP;
    endfunction

endpackage

// File: rtl/wdc_prescaler.sv
module wdc_prescaler #(
    parameter int unsigned DIV = 344064,
    parameter int unsigned PW  = 19
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          clear,
    input  logic          enable,
    output logic          tick,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    always_ff @(posedge clk) begin
        if (srst || clear) begin
            phase <= '0;
        end else if (enable) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign tick = enable && !clear && !srst && (phase == LAST);

endmodule

// File: rtl/wdc_tick_counter.sv
module wdc_tick_counter
    import wdc_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             ovf
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (srst) begin
            count <= '0;
        end else if (load) begin
            count <= reload;
        end else if (tick) begin
            count <= at_wrap(count) ? reload : count + 1'b1;
        end
    end

    assign ovf = tick && !load && !srst && at_wrap(count);

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (srst)
        (tick && !load && at_wrap(count)) |=> (count == $past(reload))); // R9

endmodule

// File: rtl/wdc_feed_guard.sv
module wdc_feed_guard
    import wdc_pkg::*;
(
    input  logic              clk,
    input  logic              srst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              unlocked
);
    feed_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            if (bus_addr == ADDR_FEED && bus_wdata == FEED_FIRST) begin
                state_d = FEED_HALF;
            end else if (state_q == FEED_HALF && bus_addr == ADDR_FEED
                         && bus_wdata == FEED_SECOND) begin
                state_d = FEED_OPEN;
            end else begin
                state_d = FEED_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) state_q <= FEED_IDLE;
        else      state_q <= state_d;
    end

    assign unlocked = (state_q == FEED_OPEN);

    AST_FEED_ONE_SHOT: assert property (@(posedge clk) disable iff (srst)
        (unlocked && bus_we) |=> !unlocked); // R11

endmodule

// File: rtl/wdc_reset_stretch.sv
module wdc_reset_stretch #(
    parameter int unsigned DIV = 344064,
    parameter int unsigned SW  = 19
) (
    input  logic clk,
    input  logic srst,
    input  logic trigger,
    output logic pulse
);
    localparam logic [SW-1:0] WIDTH = SW'(DIV);

    logic [SW-1:0] remain;

    always_ff @(posedge clk) begin
        if (srst) begin
            remain <= '0;
        end else if (trigger) begin
            remain <= WIDTH;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign pulse = (remain != '0);

    AST_RST_MIN_WIDTH: assert property (@(posedge clk) disable iff (srst)
        $rose(pulse) |=> pulse); // R10

endmodule

// File: rtl/dual_mode_watchdog.sv
module dual_mode_watchdog
    import wdc_pkg::*;
#(
    parameter int unsigned DIV = 344064
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              wd_rst_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    output logic              wdt_reset_out,
    output logic              irq_out,
    output logic              ovf_flag
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned SW = $clog2(DIV + 1);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             unlocked;
    logic             work_rst;
    logic             wr_ctrl, wr_reload;
    logic             ctrl_ok, reload_ok;
    logic             refresh;
    logic             active;
    logic             tick;
    logic             ovf;
    logic [PW-1:0]    phase;
    logic             unused_wdata_bits;

    assign work_rst  = por_rst || wd_rst_in;
    assign wr_ctrl   = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_reload = bus_we && (bus_addr == ADDR_RELOAD);
    assign ctrl_ok   = wr_ctrl && (!ctrl_q.rst_en || unlocked) && !wd_rst_in;
    assign reload_ok = wr_reload && (!ctrl_q.rst_en || unlocked) && !wd_rst_in;
    assign refresh   = ctrl_ok && bus_wdata[BIT_REFRESH];
    assign active    = ctrl_q.run || ctrl_q.force_on;
    assign unused_wdata_bits = ^{bus_wdata[7], bus_wdata[5:4]};

    wdc_feed_guard u_guard (
        .clk       (clk),
        .srst      (work_rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .unlocked  (unlocked)
    );

    wdc_prescaler #(.DIV(DIV), .PW(PW)) u_pre (
        .clk    (clk),
        .srst   (work_rst),
        .clear  (refresh),
        .enable (active),
        .tick   (tick),
        .phase  (phase)
    );

    wdc_tick_counter u_cnt (
        .clk    (clk),
        .srst   (work_rst),
        .load   (refresh),
        .tick   (tick),
        .reload (reload_q),
        .ovf    (ovf)
    );

    wdc_reset_stretch #(.DIV(DIV), .SW(SW)) u_stretch (
        .clk     (clk),
        .srst    (por_rst),
        .trigger (ovf && ctrl_q.rst_en),
        .pulse   (wdt_reset_out)
    );

    always_ff @(posedge clk) begin
        if (por_rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (ctrl_ok && bus_wdata[BIT_RSTEN]) begin
                ctrl_q.rst_en <= 1'b1;
            end
            if (ovf) begin
                ctrl_q.flag <= 1'b1;
            end else if (ctrl_ok && bus_wdata[BIT_FLAG]) begin
                ctrl_q.flag <= 1'b0;
            end
            if (wd_rst_in) begin
                ctrl_q.run      <= 1'b0;
                ctrl_q.force_on <= 1'b0;
                reload_q        <= '0;
            end else begin
                if (ctrl_ok) begin
                    ctrl_q.run      <= bus_wdata[BIT_RUN];
                    ctrl_q.force_on <= ctrl_q.force_on | bus_wdata[BIT_FORCE];
                end
                if (reload_ok) begin
                    reload_q <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = ctrl_to_byte(ctrl_q);
            ADDR_RELOAD: bus_rdata = reload_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign ovf_flag = ctrl_q.flag;
    assign irq_out  = ctrl_q.flag && irq_en && !ctrl_q.rst_en;

    AST_RSTEN_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        ctrl_q.rst_en |=> ctrl_q.rst_en); // R2

    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (por_rst)
        (ctrl_q.rst_en && wr_ctrl && !unlocked && !wd_rst_in)
        |=> ($stable(ctrl_q.run) && $stable(ctrl_q.force_on))); // R4

    AST_FORCE_RUNS: assert property (@(posedge clk) disable iff (por_rst)
        (ctrl_q.force_on && !refresh && !wd_rst_in) |=> (phase != $past(phase))); // R5

    AST_WD_OVF_RESET: assert property (@(posedge clk) disable iff (por_rst)
        (ovf && ctrl_q.rst_en) |=> wdt_reset_out); // R3

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (por_rst)
        ovf |=> ctrl_q.flag); // R8

    AST_LOCKED_FLAG: assert property (@(posedge clk) disable iff (por_rst)
        (ctrl_q.flag && ctrl_q.rst_en && wr_ctrl && !unlocked) |=> ctrl_q.flag); // R8

endmodule

// File: tb/dual_mode_watchdog_test.sv
module dual_mode_watchdog_test;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       por_rst, wd_rst_in, bus_we, irq_en;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       wdt_reset_out, irq_out, ovf_flag;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dual_mode_watchdog #(.DIV(DIV)) uut (
        .clk           (clk),
        .por_rst       (por_rst),
        .wd_rst_in     (wd_rst_in),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_en        (irq_en),
        .wdt_reset_out (wdt_reset_out),
        .irq_out       (irq_out),
        .ovf_flag      (ovf_flag)
    );

    function automatic int period_of(int r);
        int t;
        t = 255 - r;
        if (t < 1) t = 1;
        return t * DIV;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic feed();
        wr(2'd2, 8'h1E);
        wr(2'd2, 8'hE1);
    endtask

    task automatic wait_flag(output int c);
        c = 0;
        while (!ovf_flag && c < 5000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic pulse_wd_rst();
        wd_rst_in = 1'b1;
        @(negedge clk);
        wd_rst_in = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1-all act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int c, w, r, kind, newrun, exp_run;
        void'($urandom(32'd4711));
        por_rst = 1'b1; wd_rst_in = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0; irq_en = 1'b0;
        repeat (3) @(negedge clk);
        por_rst = 1'b0;

        rd(2'd0, v); check("R1 ctrl after por", v, 0);
        rd(2'd1, v); check("R1 reload after por", v, 0);
        check("R1 outputs after por", {wdt_reset_out, irq_out, ovf_flag}, 0);

        // timer mode period and reload
        irq_en = 1'b1;
        wr(2'd1, 8'd250);
        wr(2'd0, 8'h03);
        rd(2'd0, v); check("R6 refresh reads zero", v, 8'h01);
        wait_flag(c); check("R7 timer period 250", c, period_of(250));
        check("R13 irq in timer mode", irq_out, 1);
        check("R3 no reset in timer mode", wdt_reset_out, 0);
        wr(2'd0, 8'h05);
        wait_flag(c); check("R9 second period after reload", c, period_of(250) - 1);
        irq_en = 1'b0; #1;
        check("R13 irq gated by enable", irq_out, 0);
        irq_en = 1'b1;

        // directed and random reload values
        for (int i = 0; i < 5; i++) begin
            r = (i == 0) ? 255 : (i == 1) ? 254 : int'($urandom_range(255, 230));
            wr(2'd1, 8'(r));
            wr(2'd0, 8'h07);
            wait_flag(c); check($sformatf("R7 period reload=%0d", r), c, period_of(r));
        end

        // stop
        wr(2'd0, 8'h04);
        repeat (50) @(negedge clk);
        check("R5 stopped counter holds", ovf_flag, 0);

        // force-on
        wr(2'd1, 8'd250);
        wr(2'd0, 8'h46);
        wait_flag(c); check("R5 force runs with run=0", c, period_of(250));
        wr(2'd0, 8'h04);
        rd(2'd0, v); check("R5 force cannot be cleared", v[6], 1);
        wait_flag(c); check("R5 forced counter keeps running", c, period_of(250) - 1);

        // watchdog-reset input
        pulse_wd_rst();
        rd(2'd0, v); check("R12 wd reset clears run/force, keeps flag", v, 8'h04);
        rd(2'd1, v); check("R12 wd reset clears reload", v, 0);
        wr(2'd0, 8'h04);
        rd(2'd0, v); check("R8 flag cleared in timer mode", v, 0);

        // watchdog mode
        wr(2'd0, 8'h0B);
        rd(2'd0, v); check("R2 enable watchdog", v, 8'h09);
        wr(2'd0, 8'h08);
        rd(2'd0, v); check("R4 locked ctrl write ignored", v[0], 1);
        wr(2'd1, 8'h55);
        rd(2'd1, v); check("R4 locked reload write ignored", v, 0);

        exp_run = 1;
        for (int i = 0; i < 20; i++) begin
            kind   = int'($urandom_range(3, 0));
            newrun = int'($urandom_range(1, 0));
            case (kind)
                0: feed();
                1: begin wr(2'd2, 8'h1E); wr(2'd2, 8'hE2); end
                2: begin wr(2'd2, 8'h1E); wr(2'd2, 8'h00); wr(2'd2, 8'hE1); end
                default: ;
            endcase
            wr(2'd0, 8'(8'h0A | newrun));
            if (kind == 0) exp_run = newrun;
            rd(2'd0, v); check($sformatf("R11 random feed kind=%0d", kind), v[0], exp_run);
        end

        feed(); wr(2'd1, 8'hF0);
        rd(2'd1, v); check("R11 feed unlocks reload", v, 8'hF0);
        wr(2'd1, 8'h11);
        rd(2'd1, v); check("R11 unlock used once", v, 8'hF0);
        feed(); wr(2'd0, 8'h0B);
        wr(2'd2, 8'h1E); wr(2'd1, 8'h22); wr(2'd2, 8'hE1); wr(2'd0, 8'h0A);
        rd(2'd0, v); check("R11 interposed write cancels", v[0], 1);
        wr(2'd2, 8'h1E); wr(2'd2, 8'hE2); wr(2'd0, 8'h0A);
        rd(2'd0, v); check("R11 wrong byte cancels", v[0], 1);
        feed(); wr(2'd0, 8'h03);
        rd(2'd0, v); check("R2 enable not clearable by write", v[3], 1);

        feed(); wr(2'd0, 8'h0B);
        wait_flag(c); check("R7 watchdog timeout", c, period_of(240));
        check("R3 reset on watchdog overflow", wdt_reset_out, 1);
        check("R13 no irq in watchdog mode", irq_out, 0);
        w = 0;
        while (wdt_reset_out && w < 100) begin
            w++;
            @(negedge clk);
        end
        check("R10 reset pulse width", w, DIV);

        wr(2'd0, 8'h0F);
        check("R8 locked flag clear ignored", ovf_flag, 1);
        feed(); wr(2'd0, 8'h0F);
        check("R8 fed flag clear", ovf_flag, 0);
        rd(2'd0, v); check("R6 refresh bit reads zero in watchdog mode", v[1], 0);

        pulse_wd_rst();
        rd(2'd0, v); check("R12 wd reset keeps enable, stops run", v, 8'h08);

        por_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0;
        rd(2'd0, v); check("R2 por clears enable", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule